// File: doc/BRIEF.md
# Three-Slot Instruction Bundle Disperser

The disperser sits between an instruction fetch buffer and a bank of execution ports. Each cycle it is offered up to two 128-bit bundles. Each bundle carries three 41-bit instruction slots and a 5-bit template. The template tells the block which unit type every slot needs and whether the compiler placed a stop at the end of the bundle. The block forms the current issue group from these templates alone. It does no dependency checking of its own. It then steers each instruction of the group to a free execution port of a suitable class.

There are nine ports. Ports 0 and 1 are integer ports. Ports 2 and 3 accept integer or memory work. Ports 4 and 5 are floating-point ports. Ports 6, 7 and 8 are branch ports. Issue ends at a stop, at an illegal template, or at the first slot that finds no free port. The block reports, per port, a valid bit, the instruction and its slot index. It also reports how many slots were consumed, so the fetch buffer knows how far to advance.

Top module: `disperser_top`

## Requirements
- R1: The template sits in bundle bits [4:0] and slot k sits in bits [5+41k +: 41]. Template bits [4:1] select a slot-type triple (slot0, slot1, slot2) from this table: 0 MII, 1 MMI, 2 MFI, 3 MMF, 4 MIB, 5 MBB, 6 BBB, 7 MMB, 8 MFB, 9 IIB, 10 MFF, 11 IIF, 12 III. The letters mean I integer, M memory, F floating-point and B branch.
- R2: All results are registered. They appear on the rising clock edge after the inputs are sampled. While the synchronous active-high reset is high, all valids, the count and the illegal flag are zero.
- R3: An integer slot takes the lowest free integer port (0, then 1). Once both are used, it takes the lowest free integer-or-memory port (2, then 3).
- R4: A memory slot uses only ports 2 and 3. A floating-point slot uses only ports 4 and 5. A branch slot uses only ports 6 to 8. Within each class, slots take the lowest free port in program order.
- R5: Template bit 0 set places a stop after slot 2 of that bundle. When the first bundle carries a stop, the second bundle is not issued.
- R6: Issue halts at the first slot that finds no free port. No later slot issues, even if a port of its own class is free.
- R7: The second bundle is considered only when the first bundle is valid, fully issued and without a stop. An invalid first bundle issues nothing.
- R8: The consumed count (0 to 6) equals the number of valid ports. Each valid port carries the slot's instruction bits. Its slot index is 0 to 2 for the first bundle and 3 to 5 for the second.
- R9: Template indexes 13, 14 and 15 are illegal. A considered bundle with an illegal template issues nothing and raises the illegal flag. Slots of an earlier bundle still issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd0_vld | input | 1 | First (older) bundle present |
| bnd0_data | input | 128 | First bundle: template and three slots |
| bnd1_vld | input | 1 | Second bundle present |
| bnd1_data | input | 128 | Second bundle |
| iss_vld | output | 9 | Per-port issue valid |
| iss_instr | output | 369 | Per-port 41-bit instruction, port p at [41p +: 41] |
| iss_slot | output | 27 | Per-port 3-bit slot index, port p at [3p +: 3] |
| iss_count | output | 3 | Number of slots consumed this cycle |
| tmpl_bad | output | 1 | An illegal template stopped the group |

## Verification
Every result of this block passes through exactly one register stage. The port valids, instructions, slot indexes, consumed count and illegal flag for a pair of bundles are therefore all due on the first rising edge after those bundles are presented. The bench drives a pair of bundles on a falling edge and reads all outputs on the next falling edge, half a period after the registering edge. The bundles then change for the next scenario. The clocked properties use the same one-cycle offset, relating inputs in one cycle to outputs in the next.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int SLOT_W       = 41;
    localparam int TMPL_W       = 5;
    localparam int SLOTS_PER_B  = 3;
    localparam int NUM_BUNDLES  = 2;
    localparam int BUNDLE_W     = TMPL_W + SLOTS_PER_B * SLOT_W;
    localparam int TOT_SLOTS    = SLOTS_PER_B * NUM_BUNDLES;

    localparam int N_INT = 2;
    localparam int N_MEM = 2;
    localparam int N_FP  = 2;
    localparam int N_BR  = 3;

    typedef enum logic [1:0] {
        UT_INT = 2'd0,
        UT_MEM = 2'd1,
        UT_FP  = 2'd2,
        UT_BR  = 2'd3
    } unit_t;

    typedef struct packed {
        unit_t k2;
        unit_t k1;
        unit_t k0;
        logic  stop;
        logic  bad;
    } tmpl_info_t;

    function automatic unit_t kind_of(tmpl_info_t ti, int s);
        unit_t r;
        case (s)
            0:       r = ti.k0;
            1:       r = ti.k1;
            default: r = ti.k2;
        endcase
        return r;
    endfunction

    function automatic tmpl_info_t decode_tmpl(logic [TMPL_W-1:0] t);
        tmpl_info_t r;
        r.stop = t[0];
        r.bad  = 1'b0;
        case (t[4:1])
            4'd0:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_INT, UT_INT};
            4'd1:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_MEM, UT_INT};
            4'd2:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_FP,  UT_INT};
            4'd3:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_MEM, UT_FP };
            4'd4:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_INT, UT_BR };
            4'd5:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_BR,  UT_BR };
            4'd6:  {r.k0, r.k1, r.k2} = {UT_BR,  UT_BR,  UT_BR };
            4'd7:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_MEM, UT_BR };
            4'd8:  {r.k0, r.k1, r.k2} = {UT_MEM, UT_FP,  UT_BR };
            4'd9:  {r.k0, r.k1, r.k2} = {UT_INT, UT_INT, UT_BR };
            4'd10: {r.k0, r.k1, r.k2} = {UT_MEM, UT_FP,  UT_FP };
            4'd11: {r.k0, r.k1, r.k2} = {UT_INT, UT_INT, UT_FP };
            4'd12: {r.k0, r.k1, r.k2} = {UT_INT, UT_INT, UT_INT};
            default: begin
                {r.k0, r.k1, r.k2} = {UT_INT, UT_INT, UT_INT};
                r.bad = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/disp_tmpl_dec.sv
module disp_tmpl_dec
    import disp_pkg::*;
#(
    parameter int SW  = SLOT_W,
    parameter int TW  = TMPL_W,
    parameter int SPB = SLOTS_PER_B,
    localparam int BW = TW + SPB * SW
) (
    input  logic [BW-1:0]          bundle,
    output tmpl_info_t             info,
    output logic [SPB-1:0][SW-1:0] slots
);
    always_comb info = decode_tmpl(bundle[TW-1:0]);

    for (genvar k = 0; k < SPB; k++) begin : g_slot
        assign slots[k] = bundle[TW + k*SW +: SW];
    end
endmodule

// File: rtl/disp_port_alloc.sv
module disp_port_alloc
    import disp_pkg::*;
#(
    parameter int SW  = SLOT_W,
    parameter int SPB = SLOTS_PER_B,
    parameter int NB  = NUM_BUNDLES,
    parameter int NI  = N_INT,
    parameter int NM  = N_MEM,
    parameter int NF  = N_FP,
    parameter int NBR = N_BR,
    localparam int NP     = NI + NM + NF + NBR,
    localparam int TS     = SPB * NB,
    localparam int IDX_W  = $clog2(TS),
    localparam int CNT_W  = $clog2(TS + 1),
    localparam int BASE_M = NI,
    localparam int BASE_F = NI + NM,
    localparam int BASE_B = NI + NM + NF
) (
    input  logic [NB-1:0]                   b_vld,
    input  tmpl_info_t [NB-1:0]             b_info,
    input  logic [NB-1:0][SPB-1:0][SW-1:0]  b_slots,
    output logic [NP-1:0]                   p_vld,
    output logic [NP-1:0][SW-1:0]           p_instr,
    output logic [NP-1:0][IDX_W-1:0]        p_slot,
    output logic [CNT_W-1:0]                used,
    output logic                            hit_bad
);
    always_comb begin
        int    ni, nm, nf, nb, tgt;
        logic  live, prev_stop;
        unit_t kd;

        p_vld     = '0;
        p_instr   = '0;
        p_slot    = '0;
        used      = '0;
        hit_bad   = 1'b0;
        ni = 0; nm = 0; nf = 0; nb = 0;
        live      = 1'b1;
        prev_stop = 1'b0;

        for (int b = 0; b < NB; b++) begin
            // a bundle enters the group only if everything before it went out
            live = live && b_vld[b] && !prev_stop;
            if (live && b_info[b].bad) begin
                hit_bad = 1'b1;
                live    = 1'b0;
            end
            for (int s = 0; s < SPB; s++) begin
                if (live) begin
                    kd  = kind_of(b_info[b], s);
                    tgt = -1;
                    case (kd)
                        UT_INT: begin
                            if (ni < NI) begin
                                tgt = ni; ni++;
                            end else if (nm < NM) begin
                                tgt = BASE_M + nm; nm++;
                            end
                        end
                        UT_MEM: begin
                            if (nm < NM) begin
                                tgt = BASE_M + nm; nm++;
                            end
                        end
                        UT_FP: begin
                            if (nf < NF) begin
                                tgt = BASE_F + nf; nf++;
                            end
                        end
                        default: begin
                            if (nb < NBR) begin
                                tgt = BASE_B + nb; nb++;
                            end
                        end
                    endcase
                    if (tgt < 0) begin
                        live = 1'b0;
                    end else begin
                        p_vld[tgt]   = 1'b1;
                        p_instr[tgt] = b_slots[b][s];
                        p_slot[tgt]  = IDX_W'(b * SPB + s);
                        used         = used + CNT_W'(1);
                    end
                end
            end
            prev_stop = b_info[b].stop;
        end
    end
endmodule

// File: rtl/disp_out_reg.sv
module disp_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/disperser_top.sv
module disperser_top
    import disp_pkg::*;
#(
    parameter int SW  = SLOT_W,
    parameter int TW  = TMPL_W,
    parameter int NI  = N_INT,
    parameter int NM  = N_MEM,
    parameter int NF  = N_FP,
    parameter int NBR = N_BR,
    localparam int SPB   = SLOTS_PER_B,
    localparam int NB    = NUM_BUNDLES,
    localparam int BW    = TW + SPB * SW,
    localparam int NP    = NI + NM + NF + NBR,
    localparam int TS    = SPB * NB,
    localparam int IDX_W = $clog2(TS),
    localparam int CNT_W = $clog2(TS + 1),
    localparam int OUT_W = NP + NP*SW + NP*IDX_W + CNT_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bnd0_vld,
    input  logic [BW-1:0]         bnd0_data,
    input  logic                  bnd1_vld,
    input  logic [BW-1:0]         bnd1_data,
    output logic [NP-1:0]         iss_vld,
    output logic [NP*SW-1:0]      iss_instr,
    output logic [NP*IDX_W-1:0]   iss_slot,
    output logic [CNT_W-1:0]      iss_count,
    output logic                  tmpl_bad
);
    logic [NB-1:0]                  b_vld;
    logic [NB-1:0][BW-1:0]          b_data;
    tmpl_info_t [NB-1:0]            b_info;
    logic [NB-1:0][SPB-1:0][SW-1:0] b_slots;

    assign b_vld  = {bnd1_vld, bnd0_vld};
    assign b_data = {bnd1_data, bnd0_data};

    for (genvar b = 0; b < NB; b++) begin : g_dec
        disp_tmpl_dec #(.SW(SW), .TW(TW), .SPB(SPB)) dec_i (
            .bundle (b_data[b]),
            .info   (b_info[b]),
            .slots  (b_slots[b])
        );
    end

    logic [NP-1:0]            a_vld;
    logic [NP-1:0][SW-1:0]    a_instr;
    logic [NP-1:0][IDX_W-1:0] a_slot;
    logic [CNT_W-1:0]         a_used;
    logic                     a_bad;

    disp_port_alloc #(
        .SW(SW), .SPB(SPB), .NB(NB),
        .NI(NI), .NM(NM), .NF(NF), .NBR(NBR)
    ) alloc_i (
        .b_vld   (b_vld),
        .b_info  (b_info),
        .b_slots (b_slots),
        .p_vld   (a_vld),
        .p_instr (a_instr),
        .p_slot  (a_slot),
        .used    (a_used),
        .hit_bad (a_bad)
    );

    logic [OUT_W-1:0] q_all;

    disp_out_reg #(.W(OUT_W)) oreg_i (
        .clk (clk),
        .rst (rst),
        .d   ({a_vld, a_instr, a_slot, a_used, a_bad}),
        .q   (q_all)
    );

    assign {iss_vld, iss_instr, iss_slot, iss_count, tmpl_bad} = q_all;
endmodule

// File: rtl/disp_chk.sv
module disp_chk #(
    parameter int BW = 128,
    parameter int NP = 9,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          bnd0_vld,
    input logic [BW-1:0] bnd0_data,
    input logic [NP-1:0] iss_vld,
    input logic [CW-1:0] iss_count,
    input logic          tmpl_bad
);
    // R8
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        iss_count == CW'($countones(iss_vld)));

    // R7
    no_first_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        !bnd0_vld |=> (iss_count == '0 && iss_vld == '0));

    // R5
    stop_limits_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd0_vld && bnd0_data[0]) |=> (iss_count <= CW'(3)));

    // R9
    bad_first_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd0_vld && bnd0_data[4:1] >= 4'd13) |=> (tmpl_bad && iss_count == '0));

    // R9
    bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !bnd0_vld |=> !tmpl_bad);
endmodule

bind disperser_top disp_chk #(.BW(BW), .NP(NP), .CW(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bnd0_vld  (bnd0_vld),
    .bnd0_data (bnd0_data),
    .iss_vld   (iss_vld),
    .iss_count (iss_count),
    .tmpl_bad  (tmpl_bad)
);

// File: tb/disperser_top_tb.sv
module disperser_top_tb_top;
    localparam int SW = 41;
    localparam int NP = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bnd0_vld = 1'b0, bnd1_vld = 1'b0;
    logic [127:0]  bnd0_data = '0, bnd1_data = '0;
    logic [NP-1:0] iss_vld;
    logic [NP*SW-1:0] iss_instr;
    logic [NP*3-1:0]  iss_slot;
    logic [2:0]    iss_count;
    logic          tmpl_bad;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    disperser_top dut_i (
        .clk(clk), .rst(rst),
        .bnd0_vld(bnd0_vld), .bnd0_data(bnd0_data),
        .bnd1_vld(bnd1_vld), .bnd1_data(bnd1_data),
        .iss_vld(iss_vld), .iss_instr(iss_instr), .iss_slot(iss_slot),
        .iss_count(iss_count), .tmpl_bad(tmpl_bad)
    );

    function automatic logic [SW-1:0] payload(int s);
        return SW'(64'h0_1234_5670 + 64'(s) * 64'h0_0101_1011);
    endfunction

    function automatic logic [127:0] mk_bundle(int b, logic [4:0] t);
        return {payload(b*3+2), payload(b*3+1), payload(b*3), t};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // present a pair of bundles, then read results one edge later
    task automatic apply(bit v0, logic [4:0] t0, bit v1, logic [4:0] t1);
        @(negedge clk);
        bnd0_vld  = v0;
        bnd0_data = mk_bundle(0, t0);
        bnd1_vld  = v1;
        bnd1_data = mk_bundle(1, t1);
        @(negedge clk);
    endtask

    task automatic expect_summary(logic [NP-1:0] mask, int cnt, bit bad, string req);
        check(iss_vld == mask, req, "port valids", longint'(iss_vld), longint'(mask));
        check(int'(iss_count) == cnt, req, "count", longint'(iss_count), longint'(cnt));
        check(tmpl_bad == bad, req, "illegal flag", longint'(tmpl_bad), longint'(bad));
    endtask

    task automatic expect_port(int p, int s, string req);
        check(iss_slot[p*3 +: 3] == 3'(s), req, $sformatf("port %0d slot", p),
              longint'(iss_slot[p*3 +: 3]), longint'(s));
        check(iss_instr[p*SW +: SW] == payload(s), req, $sformatf("port %0d instr", p),
              longint'(iss_instr[p*SW +: SW]), longint'(payload(s)));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        apply(1'b1, 5'b00100, 1'b1, 5'b01010);
        // R2: reset holds everything at zero
        expect_summary(9'h000, 0, 1'b0, "R2");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_stop_first();
        // MII with stop; second bundle must be ignored
        apply(1'b1, 5'b00001, 1'b1, 5'b00000);
        expect_summary(9'b000000111, 3, 1'b0, "R5");
        expect_port(2, 0, "R4");
        expect_port(0, 1, "R3");
        expect_port(1, 2, "R3");
    endtask

    task automatic t_full_six();
        // MFI then MBB, no stops
        apply(1'b1, 5'b00100, 1'b1, 5'b01010);
        expect_summary(9'b011011101, 6, 1'b0, "R8");
        expect_port(2, 0, "R4");
        expect_port(4, 1, "R4");
        expect_port(0, 2, "R3");
        expect_port(3, 3, "R8");
        expect_port(6, 4, "R8");
        expect_port(7, 5, "R8");
    endtask

    task automatic t_branch_exhaust();
        // BBB then MBB: slot 4 branch finds no port
        apply(1'b1, 5'b01100, 1'b1, 5'b01010);
        expect_summary(9'b111000100, 4, 1'b0, "R6");
        expect_port(6, 0, "R4");
        expect_port(7, 1, "R4");
        expect_port(8, 2, "R4");
        expect_port(2, 3, "R4");
    endtask

    task automatic t_int_spill();
        // III then MII: third int spills to port 2, slot 4 has nowhere
        apply(1'b1, 5'b11000, 1'b1, 5'b00000);
        expect_summary(9'b000001111, 4, 1'b0, "R3");
        expect_port(0, 0, "R3");
        expect_port(1, 1, "R3");
        expect_port(2, 2, "R3");
        expect_port(3, 3, "R4");
    endtask

    task automatic t_halt_in_order();
        // MMF then MIB: slot 3 memory blocks, slot 4 int must not issue
        apply(1'b1, 5'b00110, 1'b1, 5'b01000);
        expect_summary(9'b000011100, 3, 1'b0, "R6");
        expect_port(4, 2, "R6");
    endtask

    task automatic t_bad_first();
        apply(1'b1, 5'b11110, 1'b1, 5'b00000);
        expect_summary(9'h000, 0, 1'b1, "R9");
    endtask

    task automatic t_bad_second();
        apply(1'b1, 5'b00000, 1'b1, 5'b11010);
        expect_summary(9'b000000111, 3, 1'b1, "R9");
    endtask

    task automatic t_first_missing();
        apply(1'b0, 5'b00000, 1'b1, 5'b00000);
        expect_summary(9'h000, 0, 1'b0, "R7");
    endtask

    task automatic t_second_missing();
        apply(1'b1, 5'b00100, 1'b0, 5'b00000);
        expect_summary(9'b000010101, 3, 1'b0, "R7");
    endtask

    task automatic t_table_entry();
        // R1: entry 11 is IIF, entry 8 is MFB
        apply(1'b1, 5'b10110, 1'b1, 5'b10001);
        expect_summary(9'b001110111, 6, 1'b0, "R1");
        expect_port(4, 2, "R1");
        expect_port(2, 3, "R1");
        expect_port(5, 4, "R1");
        expect_port(6, 5, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_stop_first();
        t_full_six();
        t_branch_exhaust();
        t_int_spill();
        t_halt_in_order();
        t_bad_first();
        t_bad_second();
        t_first_missing();
        t_second_missing();
        t_table_entry();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule